// File: doc/BRIEF.md
# Microprogram Sequencer with Flag-Conditional Branching

This block keeps the address register of a microcoded controller's control store and picks the next address on every clock edge. Each microinstruction carries a 4-bit next-address select code and a jump target. The datapath supplies a carry flag and a zero flag. From these inputs the sequencer either steps to the following word or loads the jump target. The registered address drives the control store read directly, so one microinstruction is fetched and executed per cycle.

The flags are evaluated combinationally in the same cycle as the microinstruction that produces them. A single microinstruction can therefore compute a result and branch on it. Each flag has a true-sense branch and an inverted-sense branch. Codes outside the defined set fall back to a sequential step.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `csAddr` to 0 after that edge, whatever the other inputs are.
- R2: Select code 4'b0000 loads `csAddr + 1`.
- R3: Select code 4'b0001 loads `jumpAddr` with no flag condition.
- R4: Select code 4'b0010 loads `jumpAddr` when `carryFlag` is 1 and `csAddr + 1` when it is 0.
- R5: Select code 4'b1010 loads `csAddr + 1` when `carryFlag` is 1 and `jumpAddr` when it is 0.
- R6: Select code 4'b0100 loads `jumpAddr` when `zeroFlag` is 1 and `csAddr + 1` when it is 0.
- R7: Select code 4'b1100 loads `csAddr + 1` when `zeroFlag` is 1 and `jumpAddr` when it is 0.
- R8: Every other select code loads `csAddr + 1`, whatever the flags and `jumpAddr` are.
- R9: The address is 8 bits wide and the increment wraps, so 8'hFF + 1 gives 8'h00.
- R10: The flags and select code of a cycle decide the address loaded at the end of that same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nxtSel | input | 4 | Next-address select code from the current microinstruction |
| jumpAddr | input | 8 | Jump target from the current microinstruction |
| carryFlag | input | 1 | Carry status from the datapath |
| zeroFlag | input | 1 | Zero status from the datapath |
| csAddr | output | 8 | Current control store address |

## Verification
The wrap of the increment is the hardest case to reach from the ports. Stepping up from zero would take 255 cycles, so the stimulus first makes an unconditional jump to 8'hFF and then issues a sequential step. Each conditional code is driven with its flag both high and low. In every case the jump target differs from the incremented address, so a wrong branch sense changes the observed address. Undefined codes are driven with both flags high and a distinct target, so a decode that wrongly takes the jump shows up.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_STEP     = 4'b0000,
    SEL_JUMP     = 4'b0001,
    SEL_JC       = 4'b0010,
    SEL_JZ       = 4'b0100,
    SEL_JNC      = 4'b1010,
    SEL_JNZ      = 4'b1100
  } nxtSel_e;

  typedef struct packed {
    logic loadJump;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/useq_branch_ctl.sv
module useq_branch_ctl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] nxtSel,
  input  logic             carryFlag,
  input  logic             zeroFlag,
  output seqStrobe_t       strobe
);
  logic takeJump;

  always_comb begin
    unique case (nxtSel)
      SEL_JUMP: takeJump = 1'b1;
      SEL_JC:   takeJump = carryFlag;
      SEL_JNC:  takeJump = ~carryFlag;
      SEL_JZ:   takeJump = zeroFlag;
      SEL_JNZ:  takeJump = ~zeroFlag;
      default:  takeJump = 1'b0;
    endcase
  end

  assign strobe.loadJump = takeJump;
  assign strobe.advance  = ~takeJump;

  assert_uncond_R3: assert property (@(posedge clk) disable iff (rst)
    nxtSel == 4'b0001 |-> strobe.loadJump);
  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    nxtSel == 4'b0010 |-> strobe.loadJump == carryFlag);
  assert_ncarry_R5: assert property (@(posedge clk) disable iff (rst)
    nxtSel == 4'b1010 |-> strobe.loadJump != carryFlag);
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    nxtSel == 4'b0100 |-> strobe.loadJump == zeroFlag);
  assert_nzero_R7: assert property (@(posedge clk) disable iff (rst)
    nxtSel == 4'b1100 |-> strobe.loadJump != zeroFlag);
  assert_other_R8: assert property (@(posedge clk) disable iff (rst)
    !(nxtSel inside {4'b0001, 4'b0010, 4'b1010, 4'b0100, 4'b1100})
      |-> strobe.advance && !strobe.loadJump);
endmodule

// File: rtl/useq_addr_path.sv
module useq_addr_path
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] jumpAddr,
  output logic [ADDR_W-1:0] addrQ
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addrInc;
  logic [ADDR_W-1:0] addrNext;

  assign addrInc = addrQ + ONE;

  always_comb begin
    if (strobe.loadJump)     addrNext = jumpAddr;
    else if (strobe.advance) addrNext = addrInc;
    else                     addrNext = addrQ;
  end

  always_ff @(posedge clk) begin
    if (rst) addrQ <= '0;
    else     addrQ <= addrNext;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadJump |=> addrQ == ADDR_W'($past(addrQ) + ONE));
  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.loadJump |=> addrQ == $past(jumpAddr));
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadJump && addrQ == '1) |=> addrQ == '0);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        nxtSel,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic              carryFlag,
  input  logic              zeroFlag,
  output logic [ADDR_W-1:0] csAddr
);
  seqStrobe_t strobe;

  useq_branch_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .nxtSel    (nxtSel),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag),
    .strobe    (strobe)
  );

  useq_addr_path #(.ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .jumpAddr (jumpAddr),
    .addrQ    (csAddr)
  );
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nxtSel = 4'b0000;
  logic [7:0] jumpAddr = 8'h00;
  logic       carryFlag = 1'b0;
  logic       zeroFlag = 1'b0;
  logic [7:0] csAddr;

  int errors = 0;
  int checks = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rst(rst), .nxtSel(nxtSel), .jumpAddr(jumpAddr),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .csAddr(csAddr)
  );

  function automatic logic [7:0] refNext(logic [7:0] cur, logic [3:0] s,
                                         logic [7:0] j, logic c, logic z);
    logic jmp;
    case (s)
      4'b0001: jmp = 1'b1;
      4'b0010: jmp = c;
      4'b1010: jmp = !c;
      4'b0100: jmp = z;
      4'b1100: jmp = !z;
      default: jmp = 1'b0;
    endcase
    return jmp ? j : cur + 8'd1;
  endfunction

  task automatic step(logic [3:0] s, logic [7:0] j, logic c, logic z, string tag);
    @(negedge clk);
    rst = 1'b0; nxtSel = s; jumpAddr = j; carryFlag = c; zeroFlag = z;
    model = refNext(model, s, j, c, z);
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  task automatic doReset(logic [3:0] s, logic [7:0] j);
    @(negedge clk);
    rst = 1'b1; nxtSel = s; jumpAddr = j; carryFlag = 1'b1; zeroFlag = 1'b1;
    model = 8'h00;
    expQ.push_back(model);
    tagQ.push_back("R1");
  endtask

  // monitor: one expected item per clock edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (csAddr !== e) begin
          errors++;
          $display("FAIL %s: csAddr=%02h expected=%02h", t, csAddr, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    doReset(4'b0001, 8'h55);                    // R1 reset wins over a jump
    step(4'b0000, 8'h99, 1'b1, 1'b1, "R2");     // 0 -> 1
    step(4'b0000, 8'h99, 1'b0, 1'b0, "R2");     // 1 -> 2
    step(4'b0001, 8'h40, 1'b0, 1'b0, "R3");     // -> 40
    step(4'b0001, 8'h7A, 1'b1, 1'b0, "R3");     // -> 7A
    step(4'b0010, 8'h20, 1'b1, 1'b0, "R4");     // carry taken -> 20
    step(4'b0010, 8'h60, 1'b0, 1'b1, "R4");     // not taken -> 21
    step(4'b1010, 8'h30, 1'b1, 1'b0, "R5");     // carry set -> 22
    step(4'b1010, 8'h30, 1'b0, 1'b1, "R5");     // carry clear -> 30
    step(4'b0100, 8'h50, 1'b0, 1'b1, "R6");     // zero taken -> 50
    step(4'b0100, 8'h90, 1'b1, 1'b0, "R6");     // not taken -> 51
    step(4'b1100, 8'hA0, 1'b0, 1'b1, "R7");     // zero set -> 52
    step(4'b1100, 8'hA0, 1'b1, 1'b0, "R7");     // zero clear -> A0
    for (int k = 0; k < 16; k++) begin
      if (!(k inside {1, 2, 4, 10, 12}))
        step(4'(k), 8'hC3, 1'b1, 1'b1, "R8");   // undefined codes step
    end
    step(4'b0001, 8'hFF, 1'b0, 1'b0, "R3");
    step(4'b0000, 8'h11, 1'b0, 1'b0, "R9");     // FF -> 00
    step(4'b0001, 8'hFF, 1'b0, 1'b0, "R3");
    step(4'b0010, 8'h11, 1'b0, 1'b0, "R9");     // untaken branch wraps
    // R10: flags change every cycle and act in that cycle
    step(4'b0100, 8'h08, 1'b0, 1'b1, "R10");
    step(4'b0100, 8'h80, 1'b0, 1'b0, "R10");
    step(4'b0010, 8'h0C, 1'b1, 1'b0, "R10");
    doReset(4'b0000, 8'h00);
    step(4'b0000, 8'h00, 1'b0, 1'b0, "R2");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule